// File: doc/BRIEF.md
# Load-use interlock detector

This block is the decode-stage hazard unit of a five-stage integer pipeline. It owns the ID/EX instruction latch. Each cycle it compares the word in that latch with the word that the IF/ID latch presents. When the EX-stage word is a load, and the ID-stage word reads the register that the load will write, the block raises a stall for one cycle.

During a stall the block writes a no-op into ID/EX. It also drops the write enables of the PC and of IF/ID, so the dependent instruction is fetched again and offered once more in the next cycle. By then a bubble occupies EX, so the instruction goes through. Forwarding covers any dependence at a distance of two or more slots, so those never stall.

Instruction fields use big-endian numbering, where bit 0 is the MSB of the 32-bit word:

| Field | Bits (big-endian) | Bits (port numbering) |
|---|---|---|
| opcode | 0..5 | [31:26] |
| first source | 6..10 | [25:21] |
| middle field | 11..15 | [20:16] |

The middle field is the load's destination. In a register-register operation it is the second source. Bits 16..20 hold a register-register destination, and the block never compares them.

The stall is a plain control pin. There is no back-pressure beyond it: the surrounding pipeline must honour the two hold enables in the same cycle.

Top module: `load_use_interlock`

## Requirements
- R1: After reset, idex_valid is 0, stall and bubble are 0, and pc_we and ifid_we are 1.
- R2: Default opcodes are: load 0x23, store 0x2B, register-register ALU 0x01, register-immediate ALU 0x08, branch 0x04. A valid load in ID/EX with destination rt (bits [20:16]), and a valid register-register consumer in IF/ID whose first source (bits [25:21]) equals rt, assert stall in the same cycle.
- R3: For a register-register consumer, a match between its bits [20:16] and the load's rt stalls. A match in its destination field, bits [15:11], alone does not stall.
- R4: For a load, store, register-immediate or branch consumer, only a match in the first source (bits [25:21]) stalls. A match in its bits [20:16] alone does not stall.
- R5: A load whose rt is register 0 never stalls.
- R6: No stall occurs in any of these cases: either latch entry is invalid, the EX word is not a load, or the consumer opcode is none of the five classes.
- R7: While stall is 1, bubble is 1 and pc_we and ifid_we are both 0. Otherwise bubble is 0 and both enables are 1.
- R8: The cycle after a stall, ID/EX holds opcode 0 with idex_valid 0, and bits [25:0] are kept from IF/ID. The held consumer then does not stall again, so exactly one bubble is inserted.
- R9: In a cycle without a stall, ID/EX takes ifid_instr and ifid_valid at the next clock edge.
- R10: A dependent instruction two slots behind a load does not stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ifid_instr | input | 32 | Instruction word in the IF/ID latch |
| ifid_valid | input | 1 | IF/ID entry holds a real instruction |
| idex_instr | output | 32 | Instruction word in the ID/EX latch |
| idex_valid | output | 1 | ID/EX entry holds a real instruction |
| stall | output | 1 | Load-use interlock active this cycle |
| bubble | output | 1 | No-op is written into ID/EX at the next edge |
| pc_we | output | 1 | PC write enable |
| ifid_we | output | 1 | IF/ID write enable |

## Verification
The bubble written into ID/EX and the hazard test on the next word can fall in the same cycle. This happens when a dependent load follows a load, and then a consumer of that second load is fetched. The stall from the first pair must clear while the second load waits, and then rise again once the second load reaches EX.

The bench provokes this with a chained load sequence. It judges that every stall lasts exactly one cycle, that each bubble carries opcode 0 with valid low, and that the second stall appears only in the cycle after the second load has entered ID/EX.

// File: rtl/lui_pkg.sv
package lui_pkg;
  localparam int INSTR_W = 32;
  localparam int OP_W    = 6;
  localparam int REG_W   = 5;
  // port-numbered top bit of each big-endian field
  localparam int OP_HI   = INSTR_W - 1;
  localparam int RS1_HI  = OP_HI - OP_W;
  localparam int MID_HI  = RS1_HI - REG_W;

  typedef enum logic [2:0] {
    CL_NONE,
    CL_LOAD,
    CL_STORE,
    CL_ALUR,
    CL_ALUI,
    CL_BRANCH
  } opclass_e;
endpackage

// File: rtl/hzd_opclass.sv
module hzd_opclass
  import lui_pkg::*;
#(
  parameter logic [OP_W-1:0] OP_LOAD   = 6'h23,
  parameter logic [OP_W-1:0] OP_STORE  = 6'h2B,
  parameter logic [OP_W-1:0] OP_ALUR   = 6'h01,
  parameter logic [OP_W-1:0] OP_ALUI   = 6'h08,
  parameter logic [OP_W-1:0] OP_BRANCH = 6'h04
) (
  input  logic [OP_W-1:0] op,
  output opclass_e        cls
);
  always_comb begin
    if (op == OP_LOAD)        cls = CL_LOAD;
    else if (op == OP_STORE)  cls = CL_STORE;
    else if (op == OP_ALUR)   cls = CL_ALUR;
    else if (op == OP_ALUI)   cls = CL_ALUI;
    else if (op == OP_BRANCH) cls = CL_BRANCH;
    else                      cls = CL_NONE;
  end
endmodule

// File: rtl/hzd_match.sv
module hzd_match
  import lui_pkg::*;
(
  input  logic             prod_valid,
  input  opclass_e         prod_cls,
  input  logic [REG_W-1:0] prod_rt,
  input  logic             cons_valid,
  input  opclass_e         cons_cls,
  input  logic [REG_W-1:0] cons_rs1,
  input  logic [REG_W-1:0] cons_mid,
  output logic             hit
);
  logic live;
  logic rs1_eq;
  logic mid_eq;

  always_comb begin
    live   = prod_valid && cons_valid && (prod_cls == CL_LOAD) && (prod_rt != '0);
    rs1_eq = (cons_rs1 == prod_rt);
    mid_eq = (cons_mid == prod_rt);
    unique case (cons_cls)
      CL_ALUR:                                hit = live && (rs1_eq || mid_eq);
      CL_LOAD, CL_STORE, CL_ALUI, CL_BRANCH:  hit = live && rs1_eq;
      default:                                hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/hzd_idex_reg.sv
module hzd_idex_reg
  import lui_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               kill,
  input  logic [INSTR_W-1:0] in_word,
  input  logic               in_valid,
  output logic [INSTR_W-1:0] out_word,
  output logic               out_valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_word  <= '0;
      out_valid <= 1'b0;
    end else if (kill) begin
      out_word  <= {{OP_W{1'b0}}, in_word[RS1_HI:0]};
      out_valid <= 1'b0;
    end else begin
      out_word  <= in_word;
      out_valid <= in_valid;
    end
  end
endmodule

// File: rtl/load_use_interlock.sv
module load_use_interlock
  import lui_pkg::*;
#(
  parameter logic [OP_W-1:0] OP_LOAD   = 6'h23,
  parameter logic [OP_W-1:0] OP_STORE  = 6'h2B,
  parameter logic [OP_W-1:0] OP_ALUR   = 6'h01,
  parameter logic [OP_W-1:0] OP_ALUI   = 6'h08,
  parameter logic [OP_W-1:0] OP_BRANCH = 6'h04
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INSTR_W-1:0] ifid_instr,
  input  logic               ifid_valid,
  output logic [INSTR_W-1:0] idex_instr,
  output logic               idex_valid,
  output logic               stall,
  output logic               bubble,
  output logic               pc_we,
  output logic               ifid_we
);
  localparam int NSLOT = 2;  // slot 0: EX producer, slot 1: ID consumer

  logic [INSTR_W-1:0] slot_word [NSLOT];
  opclass_e           slot_cls  [NSLOT];
  logic [INSTR_W-1:0] q_word;
  logic               q_valid;
  logic               hit;

  assign slot_word[0] = q_word;
  assign slot_word[1] = ifid_instr;

  for (genvar s = 0; s < NSLOT; s++) begin : g_cls
    hzd_opclass #(
      .OP_LOAD(OP_LOAD), .OP_STORE(OP_STORE), .OP_ALUR(OP_ALUR),
      .OP_ALUI(OP_ALUI), .OP_BRANCH(OP_BRANCH)
    ) u_cls (
      .op  (slot_word[s][OP_HI -: OP_W]),
      .cls (slot_cls[s])
    );
  end

  hzd_match u_match (
    .prod_valid (q_valid),
    .prod_cls   (slot_cls[0]),
    .prod_rt    (q_word[MID_HI -: REG_W]),
    .cons_valid (ifid_valid),
    .cons_cls   (slot_cls[1]),
    .cons_rs1   (ifid_instr[RS1_HI -: REG_W]),
    .cons_mid   (ifid_instr[MID_HI -: REG_W]),
    .hit        (hit)
  );

  hzd_idex_reg u_idex (
    .clk       (clk),
    .rst_n     (rst_n),
    .kill      (hit),
    .in_word   (ifid_instr),
    .in_valid  (ifid_valid),
    .out_word  (q_word),
    .out_valid (q_valid)
  );

  assign idex_instr = q_word;
  assign idex_valid = q_valid;
  assign stall      = hit;
  assign bubble     = hit;
  assign pc_we      = !hit;
  assign ifid_we    = !hit;
endmodule

// File: rtl/lui_checker.sv
module lui_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] ifid_instr,
  input logic        ifid_valid,
  input logic [31:0] idex_instr,
  input logic        idex_valid,
  input logic        stall,
  input logic        bubble,
  input logic        pc_we,
  input logic        ifid_we
);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (bubble && !pc_we && !ifid_we));

  p_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |-> (!bubble && pc_we && ifid_we));

  p_one_bubble_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);

  p_noop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (!idex_valid && idex_instr[31:26] == 6'd0
               && idex_instr[25:0] == $past(ifid_instr[25:0])));

  p_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> (idex_instr == $past(ifid_instr) && idex_valid == $past(ifid_valid)));

  p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (idex_instr[20:16] == 5'd0) |-> !stall);

  p_invalid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!idex_valid || !ifid_valid) |-> !stall);
endmodule

bind load_use_interlock lui_checker u_lui_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ifid_instr (ifid_instr),
  .ifid_valid (ifid_valid),
  .idex_instr (idex_instr),
  .idex_valid (idex_valid),
  .stall      (stall),
  .bubble     (bubble),
  .pc_we      (pc_we),
  .ifid_we    (ifid_we)
);

// File: tb/load_use_interlock_bench.sv
`timescale 1ns/1ps
module load_use_interlock_bench;
  localparam logic [5:0] LD = 6'h23, ST = 6'h2B, AR = 6'h01, AI = 6'h08, BR = 6'h04;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ifid_instr = '0;
  logic        ifid_valid = 1'b0;
  logic [31:0] idex_instr;
  logic        idex_valid, stall, bubble, pc_we, ifid_we;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  load_use_interlock u_load_use_interlock (
    .clk(clk), .rst_n(rst_n), .ifid_instr(ifid_instr), .ifid_valid(ifid_valid),
    .idex_instr(idex_instr), .idex_valid(idex_valid), .stall(stall),
    .bubble(bubble), .pc_we(pc_we), .ifid_we(ifid_we)
  );

  function automatic logic [31:0] mk_r(logic [5:0] op, logic [4:0] a, logic [4:0] b, logic [4:0] d);
    return {op, a, b, d, 11'd0};
  endfunction
  function automatic logic [31:0] mk_i(logic [5:0] op, logic [4:0] a, logic [4:0] t, logic [15:0] imm);
    return {op, a, t, imm};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic put(input logic [31:0] w, input logic v);
    ifid_instr = w;
    ifid_valid = v;
    #1;
  endtask

  task automatic check_ctrl(input string tag, input logic exp_stall);
    chk({tag, " stall"}, {31'd0, stall}, {31'd0, exp_stall});
    chk({tag, " R7 bubble"}, {31'd0, bubble}, {31'd0, exp_stall});
    chk({tag, " R7 pc_we"}, {31'd0, pc_we}, {31'd0, !exp_stall});
    chk({tag, " R7 ifid_we"}, {31'd0, ifid_we}, {31'd0, !exp_stall});
  endtask

  task automatic run_pair(input string tag, input logic [31:0] prod, input logic pv,
                          input logic [31:0] cons, input logic cv, input logic exp_stall);
    put(prod, pv);
    tick();
    put(cons, cv);
    check_ctrl(tag, exp_stall);
    tick();
    if (exp_stall) begin
      chk({tag, " R8 bubble word"}, idex_instr, {6'd0, cons[25:0]});
      chk({tag, " R8 bubble valid"}, {31'd0, idex_valid}, 32'd0);
      chk({tag, " R8 no second stall"}, {31'd0, stall}, 32'd0);
      tick();
    end
    chk({tag, " R9 idex word"}, idex_instr, cons);
    chk({tag, " R9 idex valid"}, {31'd0, idex_valid}, {31'd0, cv});
    put(32'd0, 1'b0);
    tick();
  endtask

  task automatic t_reset();
    chk("R1 idex_valid", {31'd0, idex_valid}, 32'd0);
    check_ctrl("R1 reset", 1'b0);
  endtask

  task automatic t_alur();
    run_pair("R2 rr rs1 match", mk_i(LD, 5'd2, 5'd7, 16'h10), 1, mk_r(AR, 5'd7, 5'd3, 5'd9), 1, 1);
    run_pair("R3 rr rs2 match", mk_i(LD, 5'd2, 5'd7, 16'h10), 1, mk_r(AR, 5'd4, 5'd7, 5'd9), 1, 1);
    run_pair("R3 rr rd only",   mk_i(LD, 5'd2, 5'd7, 16'h10), 1, mk_r(AR, 5'd4, 5'd5, 5'd7), 1, 0);
  endtask

  task automatic t_other_classes();
    run_pair("R4 store rs1",  mk_i(LD, 5'd1, 5'd6, 16'h0), 1, mk_i(ST, 5'd6, 5'd2, 16'h4), 1, 1);
    run_pair("R4 store mid",  mk_i(LD, 5'd1, 5'd6, 16'h0), 1, mk_i(ST, 5'd2, 5'd6, 16'h4), 1, 0);
    run_pair("R4 alui rs1",   mk_i(LD, 5'd1, 5'd6, 16'h0), 1, mk_i(AI, 5'd6, 5'd8, 16'h1), 1, 1);
    run_pair("R4 alui mid",   mk_i(LD, 5'd1, 5'd6, 16'h0), 1, mk_i(AI, 5'd3, 5'd6, 16'h1), 1, 0);
    run_pair("R4 branch rs1", mk_i(LD, 5'd1, 5'd6, 16'h0), 1, mk_i(BR, 5'd6, 5'd0, 16'h8), 1, 1);
    run_pair("R4 load rs1",   mk_i(LD, 5'd1, 5'd6, 16'h0), 1, mk_i(LD, 5'd6, 5'd9, 16'h2), 1, 1);
  endtask

  task automatic t_zero();
    run_pair("R5 rt zero", mk_i(LD, 5'd1, 5'd0, 16'h0), 1, mk_r(AR, 5'd0, 5'd0, 5'd3), 1, 0);
  endtask

  task automatic t_invalid();
    run_pair("R6 prod invalid", mk_i(LD, 5'd1, 5'd6, 16'h0), 0, mk_r(AR, 5'd6, 5'd6, 5'd3), 1, 0);
    run_pair("R6 cons invalid", mk_i(LD, 5'd1, 5'd6, 16'h0), 1, mk_r(AR, 5'd6, 5'd6, 5'd3), 0, 0);
    run_pair("R6 prod not load", mk_i(AI, 5'd1, 5'd6, 16'h0), 1, mk_r(AR, 5'd6, 5'd6, 5'd3), 1, 0);
    run_pair("R6 cons unknown op", mk_i(LD, 5'd1, 5'd6, 16'h0), 1, mk_i(6'h3F, 5'd6, 5'd6, 16'h0), 1, 0);
  endtask

  task automatic t_distance();
    put(mk_i(LD, 5'd1, 5'd5, 16'h0), 1);
    tick();
    put(mk_r(AR, 5'd2, 5'd3, 5'd4), 1);
    check_ctrl("R10 independent", 1'b0);
    tick();
    put(mk_r(AR, 5'd5, 5'd5, 5'd6), 1);
    check_ctrl("R10 two behind", 1'b0);
    tick();
    chk("R10 idex word", idex_instr, mk_r(AR, 5'd5, 5'd5, 5'd6));
    put(32'd0, 1'b0);
    tick();
  endtask

  task automatic t_chain();
    logic [31:0] l2;
    l2 = mk_i(LD, 5'd3, 5'd4, 16'h0);
    put(mk_i(LD, 5'd1, 5'd3, 16'h0), 1);
    tick();
    put(l2, 1);
    check_ctrl("R8 chain first", 1'b1);
    tick();
    chk("R8 chain bubble valid", {31'd0, idex_valid}, 32'd0);
    check_ctrl("R8 chain held", 1'b0);
    tick();
    chk("R9 chain second load in EX", idex_instr, l2);
    put(mk_r(AR, 5'd9, 5'd4, 5'd1), 1);
    check_ctrl("R3 chain second", 1'b1);
    tick();
    chk("R8 chain second bubble", idex_instr, {6'd0, ifid_instr[25:0]});
    check_ctrl("R8 chain second held", 1'b0);
    put(32'd0, 1'b0);
    tick();
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #500_000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    #1;
    t_reset();
    tick();
    t_alur();
    t_other_classes();
    t_zero();
    t_invalid();
    t_distance();
    t_chain();
    summary();
  end
endmodule